// File: doc/BRIEF.md
# Disk Channel Interrupt Status Registers

This block gathers the two interrupt causes of a single disk channel, a device
interrupt and a bus transfer error, into a small bank of 32-bit registers. Software
sees the pending causes in a status word, turns causes on through a
write-one-to-set enable word, and retires them through a write-one-to-clear word.
Each of these three words has its own word index. When a transfer error is
reported, the block also records the 64-bit bus address that failed. Software
reads that address as two 32-bit halves.

One level interrupt output is raised while any enabled cause is pending. The
device status register is outside this block, but the block takes a hook from it.
A pulse that marks a read of the device status, presented while the device is not
busy, retires the pending causes in the same way a clear write does.

The register port is a plain single-cycle port with no back-pressure. A write
takes effect at the clock edge on which `reg_wr` is high. Read data is a
combinational function of `reg_addr`, and reads have no side effects.

Top module: `ch_irq_regs`

## Requirements
- R1: After reset, the pending bits, the enable bits, the captured error address and `irq_out` are all zero.
- R2: A `dev_irq` pulse sets status bit 0, and an `xfer_err` pulse sets status bit 1. The status word is read at word index 3, and its bits 31:2 always read 0. A pending bit never sets without its event.
- R3: A write to word index 7 clears each pending bit whose matching write-data bit (bit 0 or bit 1) is 1 and leaves the others unchanged. Writing 0x03 leaves the status word reading 0.
- R4: A write to word index 5 ORs write-data bits 1:0 into the enable bits, which read back at word index 5. Writing 0 there changes nothing, and enable bits only clear at reset.
- R5: `irq_out` is high exactly when some pending bit has its enable bit set. It follows the registers in the same cycle, with no extra delay.
- R6: An event that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R7: A `stat_rd` pulse while `dev_busy` is 0 clears both pending bits. While `dev_busy` is 1 it has no effect.
- R8: An `xfer_err` that arrives while status bit 1 is clear captures `xfer_err_addr`. Bits 31:0 read at word index 0 and bits 63:32 at word index 1. Further errors while bit 1 stays set do not overwrite it.
- R9: Word indices 2, 4 and 6 read 0, and a write to the status word (index 3) changes no state.
- R10: An error arriving in the same cycle that bit 1 is cleared captures its new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register word index |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| dev_irq | input | 1 | Device interrupt event pulse |
| xfer_err | input | 1 | Bus transfer error event pulse |
| xfer_err_addr | input | 2*DATA_W | Failing bus address, valid with `xfer_err` |
| stat_rd | input | 1 | Pulse marking a read of the device status |
| dev_busy | input | 1 | Device busy flag |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
The hardest situations to reach are collisions inside one clock: an event landing
in the same cycle as a register clear, or as a status-read clear, with each
possible enable mask in force. The bench reaches them with a nested sweep over the
enable mask, the starting pending bits, the clear mask, the coincident events and
the three status-read modes. Every pending state is built from events just before
the colliding cycle. The address latch collision is driven on purpose: an error is
injected on the very edge that clears bit 1, and the bench then checks that the new
address replaced the held one.

// File: rtl/ch_irq_pkg.sv
package ch_irq_pkg;
  // Word indices whose placement software depends on
  localparam int IDX_ERR_LO = 0;
  localparam int IDX_ERR_HI = 1;
  localparam int IDX_STATUS = 3;
  localparam int IDX_ENSET  = 5;
  localparam int IDX_CLEAR  = 7;

  // Cause positions in the status word
  localparam int SRC_DEV = 0;
  localparam int SRC_ERR = 1;
  localparam int NUM_SRC = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/ch_irq_src_bit.sv
module ch_irq_src_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_set_i,
  output logic pend_o,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      // a fresh event outranks any clear in the same cycle
      pend_o <= set_i | (pend_o & ~clr_i);
      en_o   <= en_o | en_set_i;
    end
  end
endmodule

// File: rtl/ch_irq_err_capture.sv
module ch_irq_err_capture #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_i,
  input  logic [AW-1:0] addr_i,
  input  logic          err_pend_i,
  input  logic          err_clr_i,
  output logic [AW-1:0] addr_o
);
  logic take;

  // the slot is free when no error is held, or when the held one retires now
  assign take = err_i & (~err_pend_i | err_clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_o <= '0;
    else if (take) addr_o <= addr_i;
  end
endmodule

// File: rtl/ch_irq_rd_mux.sv
module ch_irq_rd_mux
  import ch_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  src_vec_t            pend_i,
  input  src_vec_t            en_i,
  input  logic [2*DATA_W-1:0] ea_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(IDX_ERR_LO))      rdata_o = ea_i[DATA_W-1:0];
    else if (addr_i == ADDR_W'(IDX_ERR_HI)) rdata_o = ea_i[2*DATA_W-1:DATA_W];
    else if (addr_i == ADDR_W'(IDX_STATUS)) rdata_o = {{PAD_W{1'b0}}, pend_i};
    else if (addr_i == ADDR_W'(IDX_ENSET))  rdata_o = {{PAD_W{1'b0}}, en_i};
  end
endmodule

// File: rtl/ch_irq_regs.sv
module ch_irq_regs
  import ch_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                dev_irq,
  input  logic                xfer_err,
  input  logic [2*DATA_W-1:0] xfer_err_addr,
  input  logic                stat_rd,
  input  logic                dev_busy,
  output logic                irq_out
);
  localparam int EA_W = 2 * DATA_W;

  src_vec_t evt_vec, clr_vec, ens_vec, pend, en;
  logic [EA_W-1:0] err_addr_q;
  logic wr_clear, wr_enset, rd_clear;

  assign wr_clear = reg_wr && (reg_addr == ADDR_W'(IDX_CLEAR));
  assign wr_enset = reg_wr && (reg_addr == ADDR_W'(IDX_ENSET));
  assign rd_clear = stat_rd && !dev_busy;

  assign evt_vec[SRC_DEV] = dev_irq;
  assign evt_vec[SRC_ERR] = xfer_err;

  assign clr_vec = (wr_clear ? reg_wdata[NUM_SRC-1:0] : '0) | {NUM_SRC{rd_clear}};
  assign ens_vec =  wr_enset ? reg_wdata[NUM_SRC-1:0] : '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ch_irq_src_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt_vec[g]),
      .clr_i    (clr_vec[g]),
      .en_set_i (ens_vec[g]),
      .pend_o   (pend[g]),
      .en_o     (en[g])
    );
  end

  ch_irq_err_capture #(.AW(EA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_i      (xfer_err),
    .addr_i     (xfer_err_addr),
    .err_pend_i (pend[SRC_ERR]),
    .err_clr_i  (clr_vec[SRC_ERR]),
    .addr_o     (err_addr_q)
  );

  ch_irq_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .addr_i  (reg_addr),
    .pend_i  (pend),
    .en_i    (en),
    .ea_i    (err_addr_q),
    .rdata_o (reg_rdata)
  );

  assign irq_out = |(pend & en);
endmodule

// File: rtl/ch_irq_regs_chk.sv
module ch_irq_regs_chk #(
  parameter int EA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dev_irq,
  input logic            xfer_err,
  input logic            stat_rd,
  input logic            dev_busy,
  input logic            irq_out,
  input logic [1:0]      pend,
  input logic [1:0]      en,
  input logic [1:0]      clr,
  input logic [EA_W-1:0] ea
);
  // R2
  dev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> pend[0]);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_irq && !xfer_err) |=> ((pend & ~$past(pend)) == 2'b00));

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en & $past(en)) == $past(en)));

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq && en[0]) |=> irq_out);

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_err && clr[1]) |=> pend[1]);

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !dev_busy && !dev_irq && !xfer_err) |=> (pend == 2'b00));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !clr[1]) |=> $stable(ea));
endmodule

bind ch_irq_regs ch_irq_regs_chk #(.EA_W(2*DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dev_irq  (dev_irq),
  .xfer_err (xfer_err),
  .stat_rd  (stat_rd),
  .dev_busy (dev_busy),
  .irq_out  (irq_out),
  .pend     (pend),
  .en       (en),
  .clr      (clr_vec),
  .ea       (err_addr_q)
);

// File: tb/tb_ch_irq_regs.sv
`timescale 1ns/1ps
module tb_ch_irq_regs;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              dev_irq = 1'b0;
  logic              xfer_err = 1'b0;
  logic [63:0]       xfer_err_addr = '0;
  logic              stat_rd = 1'b0;
  logic              dev_busy = 1'b0;
  logic              irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ch_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_irq(dev_irq),
    .xfer_err(xfer_err), .xfer_err_addr(xfer_err_addr), .stat_rd(stat_rd),
    .dev_busy(dev_busy), .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    reg_wr = 1'b0; dev_irq = 1'b0; xfer_err = 1'b0; stat_rd = 1'b0; dev_busy = 1'b0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DATA_W-1:0] v);
    reg_addr = ADDR_W'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic raise_err(input logic [63:0] a);
    xfer_err = 1'b1; xfer_err_addr = a;
    tick();
    xfer_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v, lo, hi;
    logic [1:0] nxt, clrm;
    do_reset();

    // R1: reset state
    rd(3, v); check("R1 status", v, 0);
    rd(5, v); check("R1 enable", v, 0);
    rd(0, lo); rd(1, hi); check("R1 err addr", {hi, lo}, 0);
    check("R1 irq_out", irq_out, 0);

    // Exhaustive collision sweep: enables x pending x clear mask x events x read mode
    for (int en = 0; en < 4; en++) begin
      do_reset();
      wr(5, en);
      rd(5, v); check("R4 enable set", v, en);
      wr(5, 0);
      rd(5, v); check("R4 zero write keeps enables", v, en);
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 4; e++)
            for (int m = 0; m < 3; m++) begin
              wr(7, 3);
              dev_irq = p[0]; xfer_err = p[1]; xfer_err_addr = 64'(p * 16 + c);
              tick(); idle();
              rd(3, v); check("R2 status after events", v, p);
              check("R5 irq after events", irq_out, |(p[1:0] & en[1:0]));
              reg_addr = 3'd7; reg_wdata = c; reg_wr = 1'b1;
              dev_irq = e[0]; xfer_err = e[1];
              stat_rd = (m != 0); dev_busy = (m == 2);
              tick(); idle();
              clrm = c[1:0] | ((m == 1) ? 2'b11 : 2'b00);
              nxt = (p[1:0] & ~clrm) | e[1:0];
              rd(3, v); check("R3/R6/R7 status after clear", v, nxt);
              check("R5 irq after clear", irq_out, |(nxt & en[1:0]));
            end
    end

    // R8 / R10: error address capture
    do_reset();
    raise_err(64'h1111_2222_3333_4444);
    rd(0, lo); rd(1, hi); check("R8 first capture", {hi, lo}, 64'h1111_2222_3333_4444);
    raise_err(64'hAAAA_BBBB_CCCC_DDDD);
    rd(0, lo); rd(1, hi); check("R8 held on second error", {hi, lo}, 64'h1111_2222_3333_4444);
    wr(7, 1);
    raise_err(64'h5555_6666_7777_8888);
    rd(0, lo); rd(1, hi); check("R8 held after clearing bit0 only", {hi, lo}, 64'h1111_2222_3333_4444);
    wr(7, 2);
    rd(0, lo); rd(1, hi); check("R8 clear keeps address", {hi, lo}, 64'h1111_2222_3333_4444);
    raise_err(64'h0123_4567_89AB_CDEF);
    rd(0, lo); rd(1, hi); check("R8 capture after clear", {hi, lo}, 64'h0123_4567_89AB_CDEF);
    reg_addr = 3'd7; reg_wdata = 2; reg_wr = 1'b1;
    xfer_err = 1'b1; xfer_err_addr = 64'hFEDC_BA98_7654_3210;
    tick(); idle();
    rd(0, lo); rd(1, hi); check("R10 capture on clearing edge", {hi, lo}, 64'hFEDC_BA98_7654_3210);
    rd(3, v); check("R10 bit1 still set", v, 2);

    // R9: unmapped words and writes to status
    wr(5, 3);
    dev_irq = 1'b1; tick(); idle();
    rd(2, v); check("R9 index 2 reads 0", v, 0);
    rd(4, v); check("R9 index 4 reads 0", v, 0);
    rd(6, v); check("R9 index 6 reads 0", v, 0);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); check("R9 status write ignored", v, 3);
    wr(3, 0);
    rd(3, v); check("R9 status zero write ignored", v, 3);
    check("R9 irq unchanged", irq_out, 1);
    rd(5, v); check("R9 enables unchanged", v, 3);

    // R7: busy blocks the read clear, then not-busy clears
    stat_rd = 1'b1; dev_busy = 1'b1; tick(); idle();
    rd(3, v); check("R7 busy read no effect", v, 3);
    stat_rd = 1'b1; tick(); idle();
    rd(3, v); check("R7 idle read clears", v, 0);
    check("R5 irq low after clear", irq_out, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule